// File: doc/BRIEF.md
# Audio Coprocessor Firmware Loader Interface

This block sits between an 8-bit host register bus and the program memory of an embedded audio coprocessor. While the host holds the coprocessor stopped and in load mode, firmware bytes are written into program memory one at a time. Each byte comes either from host writes to a data register or from a byte stream with a valid/ready handshake. Every accepted byte produces one program-memory write and then advances an internal write pointer.

Once the firmware is in place, the host sets the run bit and the coprocessor starts executing. The write pointer returns to zero only when the run bit goes from set to clear. Switching load mode off and back on keeps the pointer, so a load can be split over several sessions.

The block also passes a 7-bit command word to the coprocessor. It returns the coprocessor's status byte to the host. It keeps a sticky event flag that the coprocessor sets and that drives a level interrupt. While a stream transfer is running, host software should keep its own request and ready interrupts disabled, so that the transfer raises no spurious interrupts.

Top module: `fw_load_ctl`

## Requirements
- R1: After reset, run and load bits, command word and event flag are 0, the write pointer is 0, `pm_we` is low, and `s_ready` is low.
- R2: A host write to address 2 while load=1 and run=0 gives `pm_we` high for exactly the next cycle, with `pm_addr` equal to the pointer and `pm_wdata` equal to the byte. The pointer then increments by one.
- R3: `s_ready` is high only while load=1 and run=0. A beat with `s_valid` and `s_ready` high is written to program memory in the same way as R2.
- R4: A host write to address 2 while load=0 or run=1 writes nothing and leaves the pointer unchanged.
- R5: A write to the control register (address 0) that takes run from 1 to 0 resets the pointer to 0.
- R6: A control register write that changes only the load bit (bit 1) while run stays 0 leaves the pointer unchanged.
- R7: Control bit 0 is the run bit and drives `cp_run`. Bits 6:0 of address 1 hold the command word on `cp_cmd`.
- R8: `host_rdata` returns {5'b0, event, load, run} at address 0, {1'b0, command} at address 1, 0 at address 2 and `cp_status` at address 3.
- R9: A high cycle on `cp_evt` sets the event flag, which stays set and drives `irq`. Writing 1 to control bit 2 clears it. A set wins over a clear in the same cycle.
- R10: In a cycle where the host writes address 2, `s_ready` is low and the host byte is taken; the stream beat waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational on host_addr) |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| pm_we | output | 1 | Program memory write strobe |
| pm_addr | output | AW | Program memory write address |
| pm_wdata | output | 8 | Program memory write data |
| cp_run | output | 1 | Coprocessor run enable |
| cp_cmd | output | 7 | Command word to coprocessor |
| cp_status | input | 8 | Status byte from coprocessor |
| cp_evt | input | 1 | Event pulse from coprocessor |
| irq | output | 1 | Level interrupt from event flag |

## Verification
The bench splits a load across a load-mode toggle. A design that cleared the pointer on that toggle would rewrite address 0 instead of continuing. After a run/stop cycle it expects the next byte at address 0 again. A design that kept the pointer would write past the old image. It drives a host byte and a stream beat in the same cycle, which catches a design that drops either byte or swaps their order. It also clears the event flag in the same cycle as a new event, which catches a clear that wins.

// File: rtl/fw_load_ctl.sv
module fw_load_ctl #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [1:0]    host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  output logic          s_ready,
  output logic          pm_we,
  output logic [AW-1:0] pm_addr,
  output logic [7:0]    pm_wdata,
  output logic          cp_run,
  output logic [6:0]    cp_cmd,
  input  logic [7:0]    cp_status,
  input  logic          cp_evt,
  output logic          irq
);

  logic          run_q, load_q, evt_q;
  logic [6:0]    cmd_q;
  logic [AW-1:0] ptr_q;

  wire wr_ctrl  = host_we && (host_addr == 2'd0);
  wire wr_cmd   = host_we && (host_addr == 2'd1);
  wire data_sel = host_we && (host_addr == 2'd2);
  wire open_win = load_q && !run_q;
  wire wr_data  = data_sel && open_win;
  wire s_fire   = s_valid && s_ready;
  wire acc      = wr_data || s_fire;
  wire run_drop = wr_ctrl && run_q && !host_wdata[0];

  assign s_ready = open_win && !data_sel;
  assign cp_run  = run_q;
  assign cp_cmd  = cmd_q;
  assign irq     = evt_q;

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = {5'b0, evt_q, load_q, run_q};
      2'd1:    host_rdata = {1'b0, cmd_q};
      2'd3:    host_rdata = cp_status;
      default: host_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      load_q   <= 1'b0;
      evt_q    <= 1'b0;
      cmd_q    <= '0;
      ptr_q    <= '0;
      pm_we    <= 1'b0;
      pm_addr  <= '0;
      pm_wdata <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= host_wdata[0];
        load_q <= host_wdata[1];
      end
      if (wr_cmd) cmd_q <= host_wdata[6:0];
      if (cp_evt) evt_q <= 1'b1;
      else if (wr_ctrl && host_wdata[2]) evt_q <= 1'b0;
      pm_we <= acc;
      if (acc) begin
        pm_addr  <= ptr_q;
        pm_wdata <= wr_data ? host_wdata : s_data;
      end
      if (run_drop) ptr_q <= '0;
      else if (acc) ptr_q <= ptr_q + 1'b1;
    end
  end

  // R2
  write_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (pm_we && pm_addr == $past(ptr_q) && ptr_q == $past(ptr_q) + 1'b1));

  // R4
  ignored_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_sel && (!load_q || run_q)) |=> (!pm_we && ptr_q == $past(ptr_q)));

  // R5
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_drop |=> (ptr_q == '0));

  // R6
  ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !run_q && !host_wdata[0] && !s_fire) |=> $stable(ptr_q));

  // R3
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!cp_run && load_q));

  // R9
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_evt |=> irq);

endmodule

// File: tb/fw_load_ctl_test.sv
`timescale 1ns/1ps
module fw_load_ctl_test;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_we = 1'b0;
  logic [1:0]    host_addr = 2'd0;
  logic [7:0]    host_wdata = 8'h00;
  logic [7:0]    host_rdata;
  logic          s_valid = 1'b0;
  logic [7:0]    s_data = 8'h00;
  logic          s_ready;
  logic          pm_we;
  logic [AW-1:0] pm_addr;
  logic [7:0]    pm_wdata;
  logic          cp_run;
  logic [6:0]    cp_cmd;
  logic [7:0]    cp_status = 8'h00;
  logic          cp_evt = 1'b0;
  logic          irq;

  int n_run = 0;
  int n_fail = 0;
  logic [AW+7:0] exp_q[$];
  logic [7:0]    mem [0:(1<<AW)-1];
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  fw_load_ctl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .pm_we(pm_we), .pm_addr(pm_addr),
    .pm_wdata(pm_wdata), .cp_run(cp_run), .cp_cmd(cp_cmd),
    .cp_status(cp_status), .cp_evt(cp_evt), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pm_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R4 unexpected write", int'({pm_addr, pm_wdata}), 0);
      end else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        chk({pm_addr, pm_wdata} == e, "R2/R3 write", int'({pm_addr, pm_wdata}), int'(e));
        mem[pm_addr] = pm_wdata;
      end
    end
  end

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_addr = 2'd0;
  endtask

  task automatic load_byte(input logic [7:0] d, input logic [AW-1:0] a);
    exp_q.push_back({a, d});
    host_write(2'd2, d);
  endtask

  task automatic stream_beat(input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    s_valid = 1'b1; s_data = d;
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back({a, d});
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, r);
    chk(r == 8'h00, "R1 ctrl", r, 0);
    chk(!pm_we && !s_ready && !cp_run && !irq && cp_cmd == 0, "R1 outputs",
        {pm_we, s_ready, cp_run, irq}, 0);

    // R7 command
    host_write(2'd1, 8'hD5);
    chk(cp_cmd == 7'h55, "R7 cmd", cp_cmd, 7'h55);
    rd(2'd1, r);
    chk(r == 8'h55, "R8 cmd read", r, 8'h55);

    // enter load mode
    host_write(2'd0, 8'h02);
    #1;
    chk(s_ready == 1'b1, "R3 ready in load", s_ready, 1);
    rd(2'd0, r);
    chk(r == 8'h02, "R8 ctrl read", r, 8'h02);

    // R2 host bytes
    load_byte(8'hA0, 0);
    load_byte(8'hA1, 1);
    // R3 stream bytes
    stream_beat(8'hB0, 2);
    stream_beat(8'hB1, 3);
    stream_beat(8'hB2, 4);

    // R10 collision: host and stream in same cycle
    @(negedge clk);
    exp_q.push_back({10'd5, 8'hC0});
    exp_q.push_back({10'd6, 8'hC1});
    host_we = 1'b1; host_addr = 2'd2; host_wdata = 8'hC0;
    s_valid = 1'b1; s_data = 8'hC1;
    #1;
    chk(s_ready == 1'b0, "R10 ready low", s_ready, 0);
    @(negedge clk);
    host_we = 1'b0; host_addr = 2'd0;
    #1;
    chk(s_ready == 1'b1, "R10 stream resumes", s_ready, 1);
    @(negedge clk);
    s_valid = 1'b0;
    idle(2);

    // R6 and R4: load off, ignored byte, load back on
    host_write(2'd0, 8'h00);
    #1;
    chk(s_ready == 1'b0, "R3 ready low out of load", s_ready, 0);
    host_write(2'd2, 8'hEE);
    idle(3);
    chk(exp_q.size() == 0, "R4 ignored while load=0", exp_q.size(), 0);
    host_write(2'd0, 8'h02);
    load_byte(8'hD0, 7);
    idle(2);

    // R7 run, R4 ignored while running
    host_write(2'd0, 8'h03);
    chk(cp_run == 1'b1, "R7 run", cp_run, 1);
    #1;
    chk(s_ready == 1'b0, "R3 ready low when running", s_ready, 0);
    host_write(2'd2, 8'hFF);
    idle(3);
    chk(exp_q.size() == 0, "R4 ignored while run=1", exp_q.size(), 0);

    // R5 stop clears pointer
    host_write(2'd0, 8'h02);
    chk(cp_run == 1'b0, "R7 run clear", cp_run, 0);
    load_byte(8'hE0, 0);
    idle(3);
    chk(mem[0] == 8'hE0, "R5 rewrite at 0", mem[0], 8'hE0);
    chk(mem[1] == 8'hA1, "R5 addr 1 kept", mem[1], 8'hA1);
    chk(mem[7] == 8'hD0, "R6 resumed addr", mem[7], 8'hD0);

    // R8 status
    cp_status = 8'h3C;
    rd(2'd3, r);
    chk(r == 8'h3C, "R8 status", r, 8'h3C);
    rd(2'd2, r);
    chk(r == 8'h00, "R8 data read zero", r, 0);

    // R9 event
    @(negedge clk); cp_evt = 1'b1;
    @(negedge clk); cp_evt = 1'b0;
    chk(irq == 1'b1, "R9 set", irq, 1);
    idle(4);
    rd(2'd0, r);
    chk(irq == 1'b1 && r[2], "R9 held", r, 8'h06);
    host_write(2'd0, 8'h06);
    chk(irq == 1'b0, "R9 clear", irq, 0);
    @(negedge clk);
    cp_evt = 1'b1; host_we = 1'b1; host_addr = 2'd0; host_wdata = 8'h06;
    @(negedge clk);
    cp_evt = 1'b0; host_we = 1'b0;
    chk(irq == 1'b1, "R9 set wins", irq, 1);

    idle(3);
    chk(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule